// File: doc/BRIEF.md
# Instruction Cache with Snoop Invalidation and Code-Modification Flush

This block is a small direct-mapped instruction cache for a fetch unit. Each of its sixteen 32-byte lines is either Invalid or Shared, and nothing else. A fetch request is looked up in one cycle. On a hit, the 64-bit instruction word comes back on the next cycle. On a miss, the block allocates the line and asks memory for it. Memory returns the line as four 64-bit beats in ascending order. The requested word is handed to the fetch port one cycle after its own beat arrives, without waiting for the rest of the line.

A snoop port lets the memory system probe the cache. An inquire that hits a Shared line drops that line to Invalid. A snoop write that hits is treated as a change to code that may already be in flight. In that case the line is invalidated and a one-cycle flush pulse is raised. The pulse carries a restart address: the address of the instruction after the one that caused the snoop, taken as that instruction's address plus 8 bytes. A snoop has priority over a fetch lookup in the same cycle, and the fetch waits. A snoop that matches the line being filled does not stop the fill. The fill still completes, but that line is left Invalid at the end.

Address layout: bits [2:0] select a byte within a word and are ignored. Bits [4:3] select one of the four words (beats) in a line. Bits [8:5] are the line index. Bits [31:9] are the tag.

Top module: `icache_snoop_ctrl`

## Requirements
- R1: While reset is held, and right after it, every line is Invalid. `fetch_valid_o`, `mem_req_o`, `snp_hit_o` and `flush_o` are 0, and `fetch_ready_o` is 1 when no snoop is presented.
- R2: A fetch accepted (`fetch_req_i` and `fetch_ready_o` high at a clock edge) whose index and tag match a Shared line behaves as follows. On the next cycle `fetch_valid_o` is 1 and `fetch_data_o` is the line's word selected by address bits [4:3]. No memory request is made.
- R3: A fetch accepted on a miss does the following. It invalidates the indexed line. It raises `mem_req_o` for exactly one cycle, the cycle after acceptance, with `mem_addr_o` set to the line address (bits [4:0] zero). It holds `fetch_ready_o` low until the fourth beat has been taken. The line then becomes Shared, so a later fetch to it hits.
- R4: During a fill, beat k (0 to 3, counted in arrival order) is word k of the line. When k equals the requested word, `fetch_valid_o` is 1 on the next cycle and `fetch_data_o` equals that beat. This does not wait for the later beats.
- R5: `mem_beat_valid_i` while no fill is in progress has no effect. It produces no `fetch_valid_o` and alters no line.
- R6: A snoop with `snp_write_i`=0 (inquire) that matches a Shared line sets `snp_hit_o` for one cycle on the next cycle. The line becomes Invalid. `flush_o` stays 0.
- R7: A snoop with `snp_write_i`=1 that matches a Shared line invalidates the line. On the next cycle it sets `snp_hit_o` and `flush_o` for one cycle, with `flush_pc_o` = `snp_cause_pc_i` + 8.
- R8: A snoop that matches the index and tag of the line being filled behaves like a hit. It reports `snp_hit_o`, and also `flush_o` if it is a write. The fill and its forwarding still complete, but the line is Invalid afterwards.
- R9: A snoop that misses, or that matches only an Invalid line, changes no line. It leaves `snp_hit_o` and `flush_o` at 0.
- R10: While `snp_valid_i` is 1, `fetch_ready_o` is 0 and no fetch is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req_i | input | 1 | Fetch lookup request |
| fetch_addr_i | input | 32 | Fetch byte address |
| fetch_ready_o | output | 1 | Lookup can be accepted this cycle |
| fetch_valid_o | output | 1 | Instruction word valid |
| fetch_data_o | output | 64 | Instruction word |
| mem_req_o | output | 1 | One-cycle line-fill request |
| mem_addr_o | output | 32 | Line address of the fill |
| mem_beat_valid_i | input | 1 | Fill beat present |
| mem_beat_data_i | input | 64 | Fill beat data |
| snp_valid_i | input | 1 | Snoop present |
| snp_addr_i | input | 32 | Snoop address |
| snp_write_i | input | 1 | 1 = snoop write, 0 = inquire |
| snp_cause_pc_i | input | 32 | Address of the instruction causing the snoop |
| snp_hit_o | output | 1 | Snoop matched a line |
| flush_o | output | 1 | One-cycle pipeline flush |
| flush_pc_o | output | 32 | Restart address carried with the flush |

## Verification
The collision that matters is a snoop meeting a fetch in the same cycle. It comes in two forms: a snoop presented while a fetch request is waiting for lookup, and a snoop write to the very line whose fill is still streaming in. The bench provokes both, first in directed cycles and then in a long random mix, over a few indexes and tags so that collisions are frequent. A behavioural model judges each cycle on four points: the stalled fetch must not start a fill, the forwarded word must still appear, the flush must carry the right restart address, and the filled line must later miss again.

// File: rtl/icsc_pkg.sv
package icsc_pkg;

    localparam int ADDR_W      = 32;
    localparam int LINE_BYTES  = 32;
    localparam int BEAT_BYTES  = 8;
    localparam int NUM_LINES   = 16;
    localparam int INSTR_BYTES = 8;

    localparam int BEAT_W = BEAT_BYTES * 8;
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BSEL_W = $clog2(BEAT_BYTES);
    localparam int WORD_W = $clog2(BEATS);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BSEL_W-1:0] bsel_t;
    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        tag_t  tag;
        idx_t  idx;
        word_t word;
        bsel_t bsel;
    } addr_f_t;

    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_st_e;

    localparam word_t LAST_WORD = word_t'(BEATS - 1);

    function automatic addr_f_t split_addr(input addr_t a);
        return addr_f_t'(a);
    endfunction

    function automatic addr_t line_addr(input tag_t t, input idx_t i);
        return {t, i, {OFF_W{1'b0}}};
    endfunction

    function automatic addr_t restart_after(input addr_t pc);
        return pc + addr_t'(INSTR_BYTES);
    endfunction

endpackage

// File: rtl/icsc_tag_store.sv
module icsc_tag_store
    import icsc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t f_idx_i,
    input  tag_t f_tag_i,
    output logic f_hit_o,
    input  idx_t s_idx_i,
    input  tag_t s_tag_i,
    output logic s_hit_o,
    input  logic alloc_en_i,
    input  idx_t alloc_idx_i,
    input  logic fill_en_i,
    input  idx_t fill_idx_i,
    input  tag_t fill_tag_i,
    input  logic fill_keep_i,
    input  logic inv_en_i,
    input  idx_t inv_idx_i
);

    logic [NUM_LINES-1:0] vld;
    tag_t                 tags [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam idx_t MY_IDX = idx_t'(g);
        logic line_vld;
        tag_t line_tag;

        always_ff @(posedge clk) begin
            if (rst) begin
                line_vld <= 1'b0;
                line_tag <= '0;
            end else begin
                if (alloc_en_i && alloc_idx_i == MY_IDX) begin
                    line_vld <= 1'b0;
                end
                if (fill_en_i && fill_idx_i == MY_IDX) begin
                    line_vld <= fill_keep_i;
                    line_tag <= fill_tag_i;
                end
                if (inv_en_i && inv_idx_i == MY_IDX) begin
                    line_vld <= 1'b0;
                end
            end
        end

        assign vld[g]  = line_vld;
        assign tags[g] = line_tag;
    end

    assign f_hit_o = vld[f_idx_i] && (tags[f_idx_i] == f_tag_i);
    assign s_hit_o = vld[s_idx_i] && (tags[s_idx_i] == s_tag_i);

endmodule

// File: rtl/icsc_data_store.sv
module icsc_data_store
    import icsc_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en_i,
    input  idx_t  wr_idx_i,
    input  word_t wr_word_i,
    input  beat_t wr_data_i,
    input  idx_t  rd_idx_i,
    input  word_t rd_word_i,
    output beat_t rd_data_o
);

    beat_t mem [NUM_LINES][BEATS];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_idx_i][wr_word_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem[rd_idx_i][rd_word_i];

endmodule

// File: rtl/icsc_fill_ctrl.sv
module icsc_fill_ctrl
    import icsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  tag_t  start_tag_i,
    input  idx_t  start_idx_i,
    input  word_t start_word_i,
    input  logic  beat_valid_i,
    input  logic  poison_i,
    output logic  busy_o,
    output logic  mem_req_o,
    output addr_t mem_addr_o,
    output tag_t  fill_tag_o,
    output idx_t  fill_idx_o,
    output logic  wr_en_o,
    output word_t wr_word_o,
    output logic  fwd_o,
    output logic  done_o,
    output logic  keep_o
);

    fill_st_e st;
    word_t    cnt;
    word_t    want;
    logic     poisoned;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FILL_IDLE;
            mem_req_o  <= 1'b0;
            mem_addr_o <= '0;
            fill_tag_o <= '0;
            fill_idx_o <= '0;
            cnt        <= '0;
            want       <= '0;
            poisoned   <= 1'b0;
        end else begin
            mem_req_o <= 1'b0;
            if (st == FILL_IDLE) begin
                if (start_i) begin
                    st         <= FILL_BUSY;
                    mem_req_o  <= 1'b1;
                    mem_addr_o <= line_addr(start_tag_i, start_idx_i);
                    fill_tag_o <= start_tag_i;
                    fill_idx_o <= start_idx_i;
                    want       <= start_word_i;
                    cnt        <= '0;
                    poisoned   <= 1'b0;
                end
            end else begin
                if (poison_i) begin
                    poisoned <= 1'b1;
                end
                if (beat_valid_i) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_WORD) begin
                        st <= FILL_IDLE;
                    end
                end
            end
        end
    end

    assign busy_o    = (st == FILL_BUSY);
    assign wr_en_o   = busy_o && beat_valid_i;
    assign wr_word_o = cnt;
    assign fwd_o     = wr_en_o && (cnt == want);
    assign done_o    = wr_en_o && (cnt == LAST_WORD);
    assign keep_o    = !(poisoned || poison_i);

endmodule

// File: rtl/icache_snoop_ctrl.sv
module icache_snoop_ctrl
    import icsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fetch_req_i,
    input  logic [31:0] fetch_addr_i,
    output logic        fetch_ready_o,
    output logic        fetch_valid_o,
    output logic [63:0] fetch_data_o,
    output logic        mem_req_o,
    output logic [31:0] mem_addr_o,
    input  logic        mem_beat_valid_i,
    input  logic [63:0] mem_beat_data_i,
    input  logic        snp_valid_i,
    input  logic [31:0] snp_addr_i,
    input  logic        snp_write_i,
    input  logic [31:0] snp_cause_pc_i,
    output logic        snp_hit_o,
    output logic        flush_o,
    output logic [31:0] flush_pc_o
);

    addr_f_t f_fld;
    addr_f_t s_fld;
    logic    busy;
    logic    f_hit;
    logic    s_tag_hit;
    logic    fill_hit;
    logic    s_hit;
    logic    accept;
    logic    hit_acc;
    logic    miss_acc;
    tag_t    fill_tag;
    idx_t    fill_idx;
    logic    wr_en;
    word_t   wr_word;
    logic    fwd;
    logic    done;
    logic    keep;
    beat_t   rd_data;
    logic    unused_bits;

    assign f_fld = split_addr(addr_t'(fetch_addr_i));
    assign s_fld = split_addr(addr_t'(snp_addr_i));

    assign unused_bits = ^{f_fld.bsel, s_fld.word, s_fld.bsel};

    // a snoop takes the lookup slot; a fill owns the cache until its last beat
    assign fetch_ready_o = !busy && !snp_valid_i;
    assign accept        = fetch_req_i && fetch_ready_o;
    assign hit_acc       = accept && f_hit;
    assign miss_acc      = accept && !f_hit;

    assign fill_hit = busy && (s_fld.idx == fill_idx) && (s_fld.tag == fill_tag);
    assign s_hit    = snp_valid_i && (s_tag_hit || fill_hit);

    icsc_tag_store u_tags (
        .clk         (clk),
        .rst         (rst),
        .f_idx_i     (f_fld.idx),
        .f_tag_i     (f_fld.tag),
        .f_hit_o     (f_hit),
        .s_idx_i     (s_fld.idx),
        .s_tag_i     (s_fld.tag),
        .s_hit_o     (s_tag_hit),
        .alloc_en_i  (miss_acc),
        .alloc_idx_i (f_fld.idx),
        .fill_en_i   (done),
        .fill_idx_i  (fill_idx),
        .fill_tag_i  (fill_tag),
        .fill_keep_i (keep),
        .inv_en_i    (snp_valid_i && s_tag_hit),
        .inv_idx_i   (s_fld.idx)
    );

    icsc_data_store u_data (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (fill_idx),
        .wr_word_i (wr_word),
        .wr_data_i (beat_t'(mem_beat_data_i)),
        .rd_idx_i  (f_fld.idx),
        .rd_word_i (f_fld.word),
        .rd_data_o (rd_data)
    );

    icsc_fill_ctrl u_fill (
        .clk          (clk),
        .rst          (rst),
        .start_i      (miss_acc),
        .start_tag_i  (f_fld.tag),
        .start_idx_i  (f_fld.idx),
        .start_word_i (f_fld.word),
        .beat_valid_i (mem_beat_valid_i),
        .poison_i     (snp_valid_i && fill_hit),
        .busy_o       (busy),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .fill_tag_o   (fill_tag),
        .fill_idx_o   (fill_idx),
        .wr_en_o      (wr_en),
        .wr_word_o    (wr_word),
        .fwd_o        (fwd),
        .done_o       (done),
        .keep_o       (keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fetch_valid_o <= 1'b0;
            fetch_data_o  <= '0;
            snp_hit_o     <= 1'b0;
            flush_o       <= 1'b0;
            flush_pc_o    <= '0;
        end else begin
            fetch_valid_o <= hit_acc || fwd;
            if (hit_acc) begin
                fetch_data_o <= rd_data;
            end else if (fwd) begin
                fetch_data_o <= mem_beat_data_i;
            end
            snp_hit_o  <= s_hit;
            flush_o    <= s_hit && snp_write_i;
            flush_pc_o <= (s_hit && snp_write_i) ? restart_after(addr_t'(snp_cause_pc_i)) : '0;
        end
    end

endmodule

// File: rtl/icsc_checker.sv
module icsc_checker (
    input logic        clk,
    input logic        rst,
    input logic        fetch_req_i,
    input logic        fetch_ready_o,
    input logic        mem_req_o,
    input logic        snp_valid_i,
    input logic        snp_write_i,
    input logic [31:0] snp_cause_pc_i,
    input logic        snp_hit_o,
    input logic        flush_o,
    input logic [31:0] flush_pc_o
);

    AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |=> !mem_req_o); // R3

    AST_REQ_FROM_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> $past(fetch_req_i && fetch_ready_o)); // R3

    AST_FILL_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> !fetch_ready_o); // R3

    AST_HIT_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (rst)
        snp_hit_o |-> $past(snp_valid_i)); // R6

    AST_FLUSH_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> snp_hit_o && $past(snp_write_i)); // R7

    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> flush_pc_o == $past(snp_cause_pc_i) + 32'd8); // R7

    AST_SNOOP_NO_FILL_START: assert property (@(posedge clk) disable iff (rst)
        snp_valid_i |=> !mem_req_o); // R10

endmodule

bind icache_snoop_ctrl icsc_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_req_i    (fetch_req_i),
    .fetch_ready_o  (fetch_ready_o),
    .mem_req_o      (mem_req_o),
    .snp_valid_i    (snp_valid_i),
    .snp_write_i    (snp_write_i),
    .snp_cause_pc_i (snp_cause_pc_i),
    .snp_hit_o      (snp_hit_o),
    .flush_o        (flush_o),
    .flush_pc_o     (flush_pc_o)
);

// File: tb/icache_snoop_ctrl_test.sv
module icache_snoop_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req_i = 1'b0;
    logic [31:0] fetch_addr_i = '0;
    logic        fetch_ready_o;
    logic        fetch_valid_o;
    logic [63:0] fetch_data_o;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_beat_valid_i = 1'b0;
    logic [63:0] mem_beat_data_i = '0;
    logic        snp_valid_i = 1'b0;
    logic [31:0] snp_addr_i = '0;
    logic        snp_write_i = 1'b0;
    logic [31:0] snp_cause_pc_i = '0;
    logic        snp_hit_o;
    logic        flush_o;
    logic [31:0] flush_pc_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit stray_en = 1'b0;
    bit done_run = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    icache_snoop_ctrl uut (.*);

    function automatic logic [63:0] memfn(input logic [31:0] a);
        return {a ^ 32'h5A5A_1234, ~a};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // ---------------- memory: queued lines, beats in order with random gaps
    logic [31:0] pend [$];
    int          bcnt = 0;

    always @(negedge clk) begin
        if (rst) begin
            pend.delete();
            bcnt = 0;
            mem_beat_valid_i = 1'b0;
        end else begin
            if (mem_req_o) pend.push_back(mem_addr_o);
            if (pend.size() > 0 && $urandom_range(0, 2) != 0) begin
                mem_beat_valid_i = 1'b1;
                mem_beat_data_i  = memfn(pend[0] + 32'(bcnt * 8));
                bcnt++;
                if (bcnt == 4) begin
                    bcnt = 0;
                    void'(pend.pop_front());
                end
            end else if (stray_en && pend.size() == 0 && $urandom_range(0, 1) == 1) begin
                mem_beat_valid_i = 1'b1;
                mem_beat_data_i  = 64'hBAD0_BAD0_BAD0_BAD0;
            end else begin
                mem_beat_valid_i = 1'b0;
            end
        end
    end

    // ---------------- behavioural reference model
    bit          mv [16];
    logic [22:0] mt [16];
    bit          mbusy;
    int          mfidx, mfword, mcnt;
    logic [22:0] mftag;
    logic [31:0] mfline;
    bit          mpois;
    bit          e_fv, e_mreq, e_shit, e_flush;
    logic [63:0] e_fd;
    logic [31:0] e_maddr, e_fpc;
    string       e_ftag, e_stag;

    always @(posedge clk) begin
        int fi, fw, si;
        logic [22:0] ft, st;
        bit rdy, acc, fh, fm, sh_tag, sh, pnow;
        cycles++;
        if (rst) begin
            foreach (mv[i]) mv[i] = 1'b0;
            mbusy = 1'b0; mpois = 1'b0; mcnt = 0;
            e_fv = 0; e_mreq = 0; e_shit = 0; e_flush = 0;
            e_maddr = '0; e_fpc = '0; e_fd = '0;
            e_ftag = "R1"; e_stag = "R1";
        end else begin
            fi = int'(fetch_addr_i[8:5]); fw = int'(fetch_addr_i[4:3]); ft = fetch_addr_i[31:9];
            si = int'(snp_addr_i[8:5]);  st = snp_addr_i[31:9];
            rdy    = !mbusy && !snp_valid_i;
            acc    = fetch_req_i && rdy;
            fh     = mv[fi] && mt[fi] == ft;
            fm     = mbusy && si == mfidx && st == mftag;
            sh_tag = mv[si] && mt[si] == st;
            sh     = snp_valid_i && (sh_tag || fm);
            pnow   = snp_valid_i && fm;
            e_fv = 0; e_mreq = 0; e_ftag = "R2";
            if (acc && fh) begin
                e_fv = 1;
                e_fd = memfn({fetch_addr_i[31:5], fetch_addr_i[4:3], 3'b000});
            end
            if (mbusy) begin
                if (pnow) mpois = 1'b1;
                if (mem_beat_valid_i) begin
                    if (mcnt == mfword) begin
                        e_fv = 1; e_ftag = "R4";
                        e_fd = memfn(mfline + 32'(mcnt * 8));
                    end
                    if (mcnt == 3) begin
                        mbusy = 1'b0;
                        mv[mfidx] = !mpois;
                        mt[mfidx] = mftag;
                    end
                    mcnt++;
                end
            end
            if (acc && !fh) begin
                mbusy = 1'b1; mv[fi] = 1'b0; mfidx = fi; mftag = ft; mfword = fw;
                mfline = {fetch_addr_i[31:5], 5'b0}; mcnt = 0; mpois = 1'b0;
                e_mreq = 1; e_maddr = mfline;
            end
            if (snp_valid_i && sh_tag) mv[si] = 1'b0;
            e_shit  = sh;
            e_flush = sh && snp_write_i;
            e_fpc   = e_flush ? snp_cause_pc_i + 32'd8 : 32'd0;
            if (!snp_valid_i || !sh) e_stag = "R9";
            else if (fm)             e_stag = "R8";
            else if (snp_write_i)    e_stag = "R7";
            else                     e_stag = "R6";
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(fetch_valid_o === e_fv, e_ftag, "fetch_valid", 64'(fetch_valid_o), 64'(e_fv));
            if (e_fv) chk(fetch_data_o === e_fd, e_ftag, "fetch_data", fetch_data_o, e_fd);
            chk(mem_req_o === e_mreq, "R3", "mem_req", 64'(mem_req_o), 64'(e_mreq));
            if (e_mreq) chk(mem_addr_o === e_maddr, "R3", "mem_addr", 64'(mem_addr_o), 64'(e_maddr));
            chk(snp_hit_o === e_shit, e_stag, "snp_hit", 64'(snp_hit_o), 64'(e_shit));
            chk(flush_o === e_flush, e_stag, "flush", 64'(flush_o), 64'(e_flush));
            if (e_flush) chk(flush_pc_o === e_fpc, "R7", "flush_pc", 64'(flush_pc_o), 64'(e_fpc));
            chk(fetch_ready_o === (!mbusy && !snp_valid_i), "R10", "fetch_ready",
                64'(fetch_ready_o), 64'(!mbusy && !snp_valid_i));
        end
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            finish_run();
        end
    end

    // ---------------- stimulus
    task automatic drive(input bit fr, input logic [31:0] fa, input bit sv,
                         input logic [31:0] sa, input bit sw, input logic [31:0] pc);
        @(negedge clk);
        fetch_req_i = fr; fetch_addr_i = fa;
        snp_valid_i = sv; snp_addr_i = sa; snp_write_i = sw; snp_cause_pc_i = pc;
    endtask

    task automatic idle();
        drive(0, '0, 0, '0, 0, '0);
    endtask

    task automatic wait_fill();
        do idle(); while (mbusy);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(fetch_valid_o === 1'b0, "R1", "fetch_valid", 64'(fetch_valid_o), 64'd0);
        chk(mem_req_o === 1'b0, "R1", "mem_req", 64'(mem_req_o), 64'd0);
        chk(snp_hit_o === 1'b0, "R1", "snp_hit", 64'(snp_hit_o), 64'd0);
        chk(flush_o === 1'b0, "R1", "flush", 64'(flush_o), 64'd0);
        chk(fetch_ready_o === 1'b1, "R1", "fetch_ready", 64'(fetch_ready_o), 64'd1);
        rst = 1'b0;
        idle(); idle();

        // R3 R4: miss, fill, forward of word 2
        drive(1, 32'h0000_1050, 0, '0, 0, '0); wait_fill();
        // R2: hit on another word of the same line
        drive(1, 32'h0000_1048, 0, '0, 0, '0); idle();
        // R3: same index, other tag replaces the line; then original misses
        drive(1, 32'h0000_3058, 0, '0, 0, '0); wait_fill();
        drive(1, 32'h0000_1040, 0, '0, 0, '0); wait_fill();
        // R6: inquire hit, then the line misses again
        drive(0, '0, 1, 32'h0000_1044, 0, 32'h0000_7000); idle();
        drive(1, 32'h0000_1058, 0, '0, 0, '0); wait_fill();
        // R7: snoop write hit with restart address
        drive(0, '0, 1, 32'h0000_1050, 1, 32'h0000_4000); idle();
        // R9: snoop to the now Invalid line, and a plain miss
        drive(0, '0, 1, 32'h0000_1050, 1, 32'h0000_4100); idle();
        drive(0, '0, 1, 32'h00AB_0000, 0, 32'h0000_4200); idle();
        // R10: fetch and snoop in the same cycle, fetch waits one cycle
        drive(1, 32'h0000_2008, 1, 32'h0000_2000, 0, 32'h0000_5000);
        // R8: snoop write to the line being filled
        drive(1, 32'h0000_2008, 0, '0, 0, '0);
        drive(0, '0, 1, 32'h0000_2018, 1, 32'h0000_6000);
        wait_fill();
        drive(1, 32'h0000_2000, 0, '0, 0, '0); wait_fill();

        // R5: stray beats while idle
        stray_en = 1'b1;
        repeat (8) begin
            idle();
            #1;
            chk(fetch_valid_o === 1'b0, "R5", "stray fetch_valid", 64'(fetch_valid_o), 64'd0);
        end
        drive(1, 32'h0000_0100, 0, '0, 0, '0); wait_fill();

        // random mix over few indexes and tags
        for (int k = 0; k < 6000; k++) begin
            logic [31:0] fa, sa;
            fa = (32'($urandom_range(0, 1)) << 9) | (32'($urandom_range(0, 3)) << 5) |
                 (32'($urandom_range(0, 3)) << 3);
            sa = (32'($urandom_range(0, 1)) << 9) | (32'($urandom_range(0, 3)) << 5) |
                 32'($urandom_range(0, 31));
            drive($urandom_range(0, 1) == 1, fa, $urandom_range(0, 4) == 0, sa,
                  $urandom_range(0, 1) == 1, 32'($urandom) & 32'hFFFF_FFF8);
        end
        stray_en = 1'b0;
        wait_fill();
        idle();
        finish_run();
    end

endmodule